// File: doc/BRIEF.md
# Address Register Control Gating

This block keeps the address register (AR) of a small accumulator machine and works out its own register controls. The controls are fixed sum-of-products terms over the decoded opcode lines, the timing step, the indirect-address bit and the interrupt-cycle flag. There are three of them: take the bus, add one, and force to zero. The same inputs also give the enable that starts a memory read. The common bus, the step counter and the memory are outside the block. The bus value is presented on `bus_in`, and the 12-bit register drives the address.

A small enumerated action selects what AR does on each rising edge: `ACT_HOLD`, `ACT_CLR`, `ACT_LOAD` or `ACT_INC`. A fixed priority picks the action, and one `unique case` builds the next value from it. The action is picked again every cycle, so any action can follow any other. Reset is synchronous and active-high and forces `ACT_CLR` behaviour.

Top module: `addr_reg_ctl`

## Requirements
- R1: While `rst` is high at a rising edge, AR becomes 0x000 after that edge.
- R2: `ar_ld` is high exactly when (`irq_cyc`=0 and `tstep[0]`), or (`irq_cyc`=0 and `tstep[2]`), or (`op_dec[7]`=0 and `ind_bit`=1 and `tstep[3]`). When it is acted on, AR takes `bus_in[11:0]` at the next rising edge.
- R3: `ar_clr` is high exactly when `irq_cyc`=1 and `tstep[0]`=1. AR is 0x000 after the next edge.
- R4: `ar_inc` is high exactly when `op_dec[5]` and `tstep[4]` are both 1. AR then becomes AR+1 modulo 4096, so 0xFFF wraps to 0x000.
- R5: `mem_rd` is high exactly when (`irq_cyc`=0 and `tstep[1]`), or (`op_dec[7]`=0 and `ind_bit`=1 and `tstep[3]`), or (any of `op_dec[0]`, `op_dec[1]`, `op_dec[2]`, `op_dec[6]` together with `tstep[4]`).
- R6: When several controls are high at once, clear wins over load, and load wins over increment. With a one-hot `tstep`, at most one control is ever high.
- R7: With no control high, AR keeps its value across the edge.
- R8: Bits 15:12 of `bus_in` never reach AR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_dec | input | 8 | Decoded opcode lines, bit n = opcode n |
| ind_bit | input | 1 | Indirect-address bit of the instruction |
| irq_cyc | input | 1 | High during the interrupt cycle |
| tstep | input | 8 | One-hot timing step, bit n = step n |
| bus_in | input | 16 | Common bus value |
| ar_out | output | 12 | Address register contents |
| ar_ld | output | 1 | AR load control |
| ar_clr | output | 1 | AR clear control |
| ar_inc | output | 1 | AR increment control |
| mem_rd | output | 1 | Memory read enable |

## Verification
A full sweep covers every one-hot step with every one-hot opcode, with both indirect-bit values and both interrupt-flag values, and random bus data. This separates each product term from its neighbours: for example, a step-3 load with opcode 7 versus the other opcodes, and a step-0 load versus a step-0 clear. Bus words of all ones, followed by increments, exercise the wrap and show whether the upper bus bits leak into AR. Steps that are deliberately not one-hot raise two controls together and so expose the priority order. Idle cycles and a reset in mid-run cover holding and reset.

// File: rtl/arc_pkg.sv
package arc_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_CLR  = 2'd1,
        ACT_LOAD = 2'd2,
        ACT_INC  = 2'd3
    } ar_act_t;

    localparam int STEP_FETCH_A = 0;
    localparam int STEP_FETCH_B = 1;
    localparam int STEP_DECODE  = 2;
    localparam int STEP_INDIR   = 3;
    localparam int STEP_EXEC    = 4;
    localparam int OP_IO        = 7;
    localparam int OP_BRANCH    = 5;
endpackage

// File: rtl/arc_decode.sv
module arc_decode
    import arc_pkg::*;
#(
    parameter int NOP   = 8,
    parameter int NSTEP = 8
) (
    input  logic [NOP-1:0]   op_dec,
    input  logic             ind_bit,
    input  logic             irq_cyc,
    input  logic [NSTEP-1:0] tstep,
    output logic             ld,
    output logic             clr,
    output logic             inc,
    output logic             rd
);
    logic normal;
    logic indir;
    logic exec_rd;

    always_comb begin
        normal  = ~irq_cyc;
        indir   = ~op_dec[OP_IO] & ind_bit & tstep[STEP_INDIR];
        exec_rd = (op_dec[0] | op_dec[1] | op_dec[2] | op_dec[6]) & tstep[STEP_EXEC];
        ld  = (normal & tstep[STEP_FETCH_A]) | (normal & tstep[STEP_DECODE]) | indir;
        clr = irq_cyc & tstep[STEP_FETCH_A];
        inc = op_dec[OP_BRANCH] & tstep[STEP_EXEC];
        rd  = (normal & tstep[STEP_FETCH_B]) | indir | exec_rd;
    end
endmodule

// File: rtl/arc_reg.sv
module arc_reg
    import arc_pkg::*;
#(
    parameter int AW = 12,
    parameter int BW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic          clr,
    input  logic          inc,
    input  logic [BW-1:0] bus_in,
    output logic [AW-1:0] ar
);
    ar_act_t       act;
    logic [AW-1:0] ar_nxt;

    always_comb begin
        if (clr)      act = ACT_CLR;
        else if (ld)  act = ACT_LOAD;
        else if (inc) act = ACT_INC;
        else          act = ACT_HOLD;
    end

    always_comb begin
        unique case (act)
            ACT_CLR:  ar_nxt = '0;
            ACT_LOAD: ar_nxt = bus_in[AW-1:0];
            ACT_INC:  ar_nxt = ar + AW'(1);
            default:  ar_nxt = ar;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ar <= '0;
        else     ar <= ar_nxt;
    end

    assert_reset_zero_R1: assert property (@(posedge clk) rst |=> ar == '0);
    assert_clear_zero_R3: assert property (@(posedge clk) disable iff (rst)
        clr |=> ar == '0);
    assert_load_bus_R2: assert property (@(posedge clk) disable iff (rst)
        (ld && !clr) |=> ar == $past(bus_in[AW-1:0]));
    assert_inc_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr && !ld) |=> ar == AW'($past(ar) + AW'(1)));
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(clr || ld || inc) |=> $stable(ar));
endmodule

// File: rtl/addr_reg_ctl.sv
module addr_reg_ctl
    import arc_pkg::*;
#(
    parameter int AW    = 12,
    parameter int BW    = 16,
    parameter int NOP   = 8,
    parameter int NSTEP = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NOP-1:0]   op_dec,
    input  logic             ind_bit,
    input  logic             irq_cyc,
    input  logic [NSTEP-1:0] tstep,
    input  logic [BW-1:0]    bus_in,
    output logic [AW-1:0]    ar_out,
    output logic             ar_ld,
    output logic             ar_clr,
    output logic             ar_inc,
    output logic             mem_rd
);
    arc_decode #(.NOP(NOP), .NSTEP(NSTEP)) u_dec (
        .op_dec (op_dec),
        .ind_bit(ind_bit),
        .irq_cyc(irq_cyc),
        .tstep  (tstep),
        .ld     (ar_ld),
        .clr    (ar_clr),
        .inc    (ar_inc),
        .rd     (mem_rd)
    );

    arc_reg #(.AW(AW), .BW(BW)) u_reg (
        .clk   (clk),
        .rst   (rst),
        .ld    (ar_ld),
        .clr   (ar_clr),
        .inc   (ar_inc),
        .bus_in(bus_in),
        .ar    (ar_out)
    );

    assert_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot(tstep) |-> $onehot0({ar_clr, ar_ld, ar_inc}));
endmodule

// File: tb/sim_addr_reg_ctl.sv
module sim_addr_reg_ctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  op_dec = '0;
    logic        ind_bit = 1'b0;
    logic        irq_cyc = 1'b0;
    logic [7:0]  tstep = '0;
    logic [15:0] bus_in = '0;
    logic [11:0] ar_out;
    logic        ar_ld, ar_clr, ar_inc, mem_rd;

    int total = 0;
    int bad = 0;
    int model_ar = 0;

    always #5 clk = ~clk;

    addr_reg_ctl u0 (
        .clk(clk), .rst(rst), .op_dec(op_dec), .ind_bit(ind_bit),
        .irq_cyc(irq_cyc), .tstep(tstep), .bus_in(bus_in), .ar_out(ar_out),
        .ar_ld(ar_ld), .ar_clr(ar_clr), .ar_inc(ar_inc), .mem_rd(mem_rd)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive at falling edge, check controls, then AR after rising edge.
    task automatic step(input logic [7:0] d, input bit i, input bit r,
                        input logic [7:0] t, input logic [15:0] b);
        bit e_ld, e_clr, e_inc, e_rd;
        @(negedge clk);
        op_dec = d; ind_bit = i; irq_cyc = r; tstep = t; bus_in = b;
        #1;
        e_ld  = (!r && t[0]) || (!r && t[2]) || (!d[7] && i && t[3]);
        e_clr = r && t[0];
        e_inc = d[5] && t[4];
        e_rd  = (!r && t[1]) || (!d[7] && i && t[3]) ||
                ((d[0] || d[1] || d[2] || d[6]) && t[4]);
        check("R2 ld", int'(ar_ld), int'(e_ld));
        check("R3 clr", int'(ar_clr), int'(e_clr));
        check("R4 inc", int'(ar_inc), int'(e_inc));
        check("R5 rd", int'(mem_rd), int'(e_rd));
        if (e_clr)      model_ar = 0;
        else if (e_ld)  model_ar = int'(b) % 4096;
        else if (e_inc) model_ar = (model_ar + 1) % 4096;
        @(posedge clk); #1;
        check("R6/R7/R8 ar", int'(ar_out), model_ar);
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 reset
        bus_in = 16'hFFFF; tstep = 8'h01;
        repeat (2) @(posedge clk);
        #1 check("R1 reset", int'(ar_out), 0);
        @(negedge clk) rst = 1'b0;
        model_ar = 0;
        // full sweep of one-hot combinations
        for (int r = 0; r < 2; r++)
            for (int t = 0; t < 8; t++)
                for (int d = 0; d < 8; d++)
                    for (int i = 0; i < 2; i++)
                        step(8'(1 << d), i[0], r[0], 8'(1 << t), 16'($urandom));
        // R8 and R4 wrap: load all ones, then increment twice
        step(8'h01, 0, 0, 8'h01, 16'hFFFF);
        check("R8 upper bits", int'(ar_out), 12'hFFF);
        step(8'h20, 0, 0, 8'h10, 16'h1234);
        check("R4 wrap", int'(ar_out), 0);
        step(8'h20, 0, 0, 8'h10, 16'hF000);
        check("R4 inc", int'(ar_out), 1);
        // R7 hold with no step active
        step(8'h00, 1, 0, 8'h00, 16'hABCD);
        check("R7 hold", int'(ar_out), 1);
        // R6 priority with non one-hot steps
        step(8'h20, 0, 0, 8'h11, 16'h0456);
        check("R6 load over inc", int'(ar_out), 12'h456);
        step(8'h20, 0, 1, 8'h11, 16'h0789);
        check("R6 clr over inc", int'(ar_out), 0);
        step(8'h01, 1, 0, 8'h01, 16'h0321);
        step(8'h01, 1, 1, 8'h09, 16'h0555);
        check("R6 clr over load", int'(ar_out), 0);
        // R1 reset mid-run
        step(8'h01, 0, 0, 8'h04, 16'h0ABC);
        @(negedge clk) rst = 1'b1; tstep = 8'h00;
        @(posedge clk); #1;
        check("R1 reset midrun", int'(ar_out), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule